// File: doc/BRIEF.md
# Peripheral Clock Gate Bank

This block holds one clock-enable bit for each of up to 64 peripheral IDs and drives a clock-enable output per ID toward the clock gating cells. Software turns clocks on and off through a small register bus. Each group of 32 IDs has its own enable-write register, disable-write register and status register. In the write registers each bit acts only when it is written as one, so a driver can change one peripheral without a read-modify-write.

The two lowest IDs belong to logic that must never lose its clock. Their enables are fixed on. Writes that touch their bits change nothing, and their status bits always read as one. All other IDs come out of reset with their clocks gated off.

The register word address is `{group, reg}`. The upper bits pick the 32-ID group. The low two bits pick the register: 0 enables, 1 disables, 2 is status, and 3 is unused. The bit position of an ID inside its group register is the ID's low five bits. Reads are combinational from the current address. A write acts on the rising clock edge where the strobe is high.

Top module: `pcg_gate_bank`

## Requirements
- R1: After reset every clock-enable output for IDs 2 to 63 is 0 and the outputs for IDs 0 and 1 are 1, so `pclk_en` equals 64'h3.
- R2: IDs 0 and 1 stay enabled whatever is written: disable writes with bits 0 and 1 set leave `pclk_en[1:0]` at 2'b11, and status group 0 bits 1:0 read 2'b11.
- R3: A write to address 0 with bit k set (2 <= k <= 31) enables ID k.
- R4: A write to address 4 with bit k set enables ID 32+k, and a write to address 5 with bit k set disables ID 32+k.
- R5: A write to address 1 with bit k set disables ID k (2 <= k <= 31).
- R6: Bits written as zero to an enable or disable register leave the matching enables unchanged.
- R7: Reading address 2 returns the enables of IDs 31..0, and reading address 6 returns the enables of IDs 63..32, bit position = ID mod 32.
- R8: Reading an enable register (address 0 or 4), a disable register (address 1 or 5) or an unused address (3 or 7) returns 0.
- R9: Writes to the status addresses (2 and 6) and to the unused addresses (3 and 7) change no enable.
- R10: A write is visible on `pclk_en` and in status in the first cycle after the clock edge that takes it, and `pclk_en` always matches the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and enable clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Word address {group, register} |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, acts on the rising edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pclk_en | output | 64 | Per-ID clock enable, bit n for ID n |

## Verification
The hardest case to reach is a mix of enable and disable writes that hits both groups and the fixed-on IDs, including words with many bits set, with the group-1 bit positions lining up exactly with IDs 32 to 63. Random writes go to all eight addresses with full-width random data, so status and unused addresses also get writes that must be ignored. After every write, both status registers are read and the full 64-bit enable vector is compared against a bench model. Directed writes of all-ones and of only bits 1:0 cover the reserved IDs and group-wide enable and disable.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam int DEF_IDS    = 64;
    localparam int DEF_BANK_W = 32;
    localparam int DEF_RSVD   = 2;

    typedef enum logic [1:0] {
        REG_SET  = 2'd0,
        REG_CLR  = 2'd1,
        REG_STS  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pcg_decode.sv
module pcg_decode #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    parameter int BANK_AW   = 1,
    parameter int ADDR_W    = 3
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [BANK_W-1:0]                 wdata,
    input  logic                              we,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]  set_v,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]  clr_v,
    output logic [BANK_AW-1:0]                bank_idx,
    output pcg_pkg::reg_sel_e                 reg_sel
);
    import pcg_pkg::*;

    assign bank_idx = addr[ADDR_W-1:2];
    assign reg_sel  = reg_sel_e'(addr[1:0]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
        logic hit;
        assign hit      = we && (bank_idx == BANK_AW'(b));
        assign set_v[b] = (hit && reg_sel == REG_SET) ? wdata : '0;
        assign clr_v[b] = (hit && reg_sel == REG_CLR) ? wdata : '0;
    end
endmodule

// File: rtl/pcg_bank.sv
module pcg_bank #(
    parameter int BANK_W   = 32,
    parameter int BASE_ID  = 0,
    parameter int NUM_RSVD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] set_mask,
    input  logic [BANK_W-1:0] clr_mask,
    output logic [BANK_W-1:0] status
);
    function automatic logic [BANK_W-1:0] calc_rsvd();
        logic [BANK_W-1:0] m;
        m = '0;
        for (int i = 0; i < BANK_W; i++)
            if (BASE_ID + i < NUM_RSVD) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [BANK_W-1:0] RSVD = calc_rsvd();

    typedef struct packed {
        logic [BANK_W-1:0] en;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        // disable has priority if both land on one bit
        st_d.en = (st_q.en | set_mask) & ~clr_mask & ~RSVD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.en | RSVD;

    // R5
    disable_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(clr_mask) & ~RSVD) == '0));
    // R3
    enable_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));
    // R6
    untouched_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status ^ $past(status)) & ~$past(set_mask | clr_mask)) == '0));
    // R2
    reserved_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & RSVD) == RSVD);
endmodule

// File: rtl/pcg_gate_bank.sv
module pcg_gate_bank #(
    parameter  int NUM_IDS   = pcg_pkg::DEF_IDS,
    parameter  int BANK_W    = pcg_pkg::DEF_BANK_W,
    parameter  int NUM_RSVD  = pcg_pkg::DEF_RSVD,
    localparam int NUM_BANKS = (NUM_IDS + BANK_W - 1) / BANK_W,
    localparam int BANK_AW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = BANK_AW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BANK_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [BANK_W-1:0]  bus_rdata,
    output logic [NUM_IDS-1:0] pclk_en
);
    import pcg_pkg::*;

    logic [NUM_BANKS-1:0][BANK_W-1:0] set_v, clr_v, sts_v;
    logic [BANK_AW-1:0]               bank_idx;
    reg_sel_e                         reg_sel;

    pcg_decode #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
        .BANK_AW(BANK_AW), .ADDR_W(ADDR_W)
    ) u_dec (
        .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
        .set_v(set_v), .clr_v(clr_v),
        .bank_idx(bank_idx), .reg_sel(reg_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pcg_bank #(
            .BANK_W(BANK_W), .BASE_ID(b * BANK_W), .NUM_RSVD(NUM_RSVD)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .set_mask(set_v[b]), .clr_mask(clr_v[b]),
            .status(sts_v[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (reg_sel == REG_STS && int'(bank_idx) < NUM_BANKS)
            bus_rdata = sts_v[bank_idx];
    end

    logic [NUM_BANKS*BANK_W-1:0] flat_en;
    assign flat_en = sts_v;
    assign pclk_en = flat_en[NUM_IDS-1:0];

    // R9
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (reg_sel == REG_STS || reg_sel == REG_NONE)) |=> $stable(pclk_en));
    // R8
    write_reg_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel != REG_STS) |-> (bus_rdata == '0));
endmodule

// File: tb/pcg_gate_bank_test.sv
module pcg_gate_bank_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] pclk_en;

    int total = 0;
    int bad = 0;
    logic [63:0] model = 64'h3;

    always #(PERIOD/2) clk = ~clk;

    pcg_gate_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pclk_en(pclk_en)
    );

    function automatic logic [63:0] next_model(logic [63:0] m, logic [2:0] a, logic [31:0] d);
        logic [63:0] r;
        r = m;
        if (a[1:0] == 2'd0) begin
            if (a[2]) r[63:32] = r[63:32] | d;
            else      r[31:0]  = r[31:0]  | d;
        end else if (a[1:0] == 2'd1) begin
            if (a[2]) r[63:32] = r[63:32] & ~d;
            else      r[31:0]  = r[31:0]  & ~d;
        end
        r[1:0] = 2'b11;
        return r;
    endfunction

    function automatic logic [31:0] expect_read(logic [63:0] m, logic [2:0] a);
        if (a[1:0] != 2'd2) return 32'h0;
        return a[2] ? m[63:32] : m[31:0];
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model = next_model(model, a, d);
    endtask

    task automatic bus_read(string req, logic [2:0] a);
        bus_addr = a;
        #1;
        check(req, {32'h0, bus_rdata}, {32'h0, expect_read(model, a)});
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #(PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", pclk_en, 64'h3);
        bus_read("R7", 3'd2);
        bus_read("R7", 3'd6);

        // R2 reserved IDs cannot be disabled
        bus_write(3'd1, 32'h3);
        check("R2", pclk_en, 64'h3);
        bus_read("R2", 3'd2);

        // R3 enable group 0 bits, R10 visible the cycle after the write edge
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 32'h8000_0004; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
        model = next_model(model, 3'd0, 32'h8000_0004);
        check("R10", pclk_en, model);
        check("R3", {63'h0, pclk_en[31]}, 64'h1);

        // R4 group 1 enable and disable
        bus_write(3'd4, 32'h0000_0201);
        check("R4", pclk_en, model);
        check("R4", {63'h0, pclk_en[41]}, 64'h1);
        bus_write(3'd5, 32'h0000_0001);
        check("R4", {63'h0, pclk_en[32]}, 64'h0);

        // R5 disable group 0
        bus_write(3'd1, 32'h8000_0000);
        check("R5", {63'h0, pclk_en[31]}, 64'h0);

        // R6 zero write changes nothing
        bus_write(3'd0, 32'h0);
        check("R6", pclk_en, model);
        bus_write(3'd5, 32'h0);
        check("R6", pclk_en, model);

        // R9 writes to status and unused addresses ignored
        bus_write(3'd2, 32'hFFFF_FFFF);
        check("R9", pclk_en, model);
        bus_write(3'd7, 32'hFFFF_FFFF);
        check("R9", pclk_en, model);

        // R8 write and unused registers read zero
        bus_write(3'd4, 32'hFFFF_FFFF);
        bus_read("R8", 3'd0);
        bus_read("R8", 3'd1);
        bus_read("R8", 3'd3);
        bus_read("R8", 3'd4);
        bus_read("R8", 3'd5);
        bus_read("R8", 3'd7);
        bus_read("R7", 3'd6);
        bus_write(3'd1, 32'hFFFF_FFFF);
        check("R2", pclk_en, {32'hFFFF_FFFF, 32'h3});

        // random mix, R10 output tracks model and status
        for (int i = 0; i < 400; i++) begin
            logic [2:0]  a;
            logic [31:0] d;
            a = 3'($urandom_range(0, 7));
            d = $urandom();
            if (i % 5 == 0) d = d & $urandom();
            bus_write(a, d);
            check("R10", pclk_en, model);
            bus_read("R7", 3'd2);
            bus_read("R7", 3'd6);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule